// File: doc/BRIEF.md
# Fourteen-Tap FIR Filter with Running Total

This block is a direct-form finite impulse response filter with fourteen fixed integer weights. Each clock cycle in which the input strobe is high, it accepts one signed 16-bit sample. It forms the weighted sum of that sample and the thirteen samples accepted before it, and shifts the new sample into its history. The filtered value is registered and shown one cycle later. In that same cycle a running total of every filtered value produced since reset is updated.

Both the filtered value and the running total come with a one-cycle valid strobe and a sequential write address. A plain memory write port can therefore store each result pair at consecutive locations. A stream of stored samples is passed through by presenting them one per cycle. Gaps in the stream are allowed and leave the state untouched.

Top module: `fir_accum`

## Requirements
- R1: A synchronous active-high reset clears the sample history, the running total, the filtered output, the write address and the valid strobe to zero.
- R2: The weights are applied so that an impulse of value 1 followed by zeros produces, on successive outputs, 472, 34, 348, 181, 295, 361, 430, 260, 179, 151, 81, 68, 78, 302, then 0. The first weight goes to the newest sample and the last weight to the sample accepted thirteen strobes earlier.
- R3: Each output equals the sum over k = 0..13 of weight k times the sample accepted k strobes before the current one. Samples older than 13 strobes have no effect, and history that is missing after reset counts as zero.
- R4: The filtered output and the running total change on the clock edge after an accepted sample, and out_valid is high for exactly that one cycle per accepted sample.
- R5: On every valid output, the running total equals its previous value plus the new filtered output, sign-extended to 48 bits.
- R6: While in_valid is low, the history, the filtered output and the running total hold their values, out_valid is low, and the write address does not move.
- R7: The write address is 0 for the first output after reset and rises by one after each valid output.
- R8: Samples and products are signed two's complement, so negative samples give correctly signed outputs and totals.
- R9: Full-scale 16-bit inputs (+32767 and −32768) never wrap the 32-bit filtered output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | High for one cycle when a result pair is ready to be written |
| y_out | output | 32 | Signed filtered output |
| acc_out | output | 48 | Signed running total of all filtered outputs |
| wr_addr | output | 12 | Write address for the current result pair |

## Verification
A unit impulse separates the weights one by one, so a swapped or wrong weight shows up at its own output position. Full-scale positive and negative steps check the sign handling and the width margin, and they show the history settling after exactly fourteen samples. A pseudo-random stream with idle gaps checks that gaps neither shift the history nor advance the total or the address. A reset in the middle of a stream checks that no old history survives it.

// File: rtl/fir_accum.sv
`timescale 1ns/1ps
module fir_accum #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 32,
  parameter int ACC_W  = 48,
  parameter int ADDR_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  y_out,
  output logic signed [ACC_W-1:0]  acc_out,
  output logic [ADDR_W-1:0]        wr_addr
);
  localparam int TAPS  = 14;
  localparam int DEPTH = TAPS - 1;
  localparam int WEIGHT [TAPS] = '{472, 34, 348, 181, 295, 361, 430,
                                   260, 179, 151, 81, 68, 78, 302};

  logic signed [DATA_W-1:0] hist [DEPTH];
  logic signed [DATA_W-1:0] taps [TAPS];
  logic signed [OUT_W-1:0]  y_next;

  assign taps[0] = in_sample;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign taps[k] = hist[k-1];
  end

  always_comb begin
    y_next = '0;
    for (int k = 0; k < TAPS; k++)
      y_next += OUT_W'(taps[k]) * OUT_W'(WEIGHT[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) hist[k] <= '0;
    end else if (in_valid) begin
      hist[0] <= in_sample;
      for (int k = 1; k < DEPTH; k++) hist[k] <= hist[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_out     <= '0;
      acc_out   <= '0;
      wr_addr   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y_out   <= y_next;
        acc_out <= acc_out + ACC_W'(y_next);
      end
      if (out_valid) wr_addr <= wr_addr + 1'b1;
    end
  end
endmodule

module fir_accum_chk #(
  parameter int OUT_W  = 32,
  parameter int ACC_W  = 48,
  parameter int ADDR_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] y_out,
  input logic signed [ACC_W-1:0] acc_out,
  input logic [ADDR_W-1:0]       wr_addr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && acc_out == '0 && y_out == '0 && wr_addr == '0));
  // R4
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(y_out) && $stable(acc_out)));
  // R5
  total_step_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (acc_out - $past(acc_out) == ACC_W'(y_out)));
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> (wr_addr == $past(wr_addr) + 1'b1));
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |=> $stable(wr_addr));
endmodule

bind fir_accum fir_accum_chk #(.OUT_W(OUT_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .y_out(y_out), .acc_out(acc_out), .wr_addr(wr_addr));

// File: tb/fir_accum_tb.sv
`timescale 1ns/1ps
module fir_accum_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic out_valid;
  logic signed [31:0] y_out;
  logic signed [47:0] acc_out;
  logic [11:0] wr_addr;

  fir_accum u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
                   .out_valid(out_valid), .y_out(y_out), .acc_out(acc_out), .wr_addr(wr_addr));

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int wt [14] = '{472, 34, 348, 181, 295, 361, 430, 260, 179, 151, 81, 68, 78, 302};
  int past [$];
  longint e_y = 0, e_acc = 0;
  int e_addr = 0;
  bit e_valid = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(out_valid == e_valid, {tag, " R4/R6 out_valid"}, out_valid, e_valid);
    chk(longint'(y_out) == e_y, {tag, " R3 y_out"}, y_out, e_y);
    chk(longint'(acc_out) == e_acc, {tag, " R5 acc_out"}, acc_out, e_acc);
    chk(int'(wr_addr) == e_addr, {tag, " R7 wr_addr"}, wr_addr, e_addr);
  endtask

  task automatic step(input bit v, input int x, input bit r, input string tag);
    @(negedge clk);
    rst = r; in_valid = v; in_sample = 16'(x);
    @(posedge clk);
    #1;
    if (r) begin
      past.delete(); e_y = 0; e_acc = 0; e_addr = 0; e_valid = 0;
    end else begin
      if (e_valid) e_addr = (e_addr + 1) % 4096;
      if (v) begin
        past.push_front(x);
        if (past.size() > 14) void'(past.pop_back());
        e_y = 0;
        foreach (past[k]) e_y += longint'(past[k]) * wt[k];
        e_acc += e_y;
      end
      e_valid = v;
    end
    compare(tag);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(0, 0, 1, "R1 reset");
    step(1, 999, 1, "R1 reset");
    step(0, 0, 0, "R6 idle");
    // R2 impulse response
    step(1, 1, 0, "R2 impulse");
    for (int i = 0; i < 15; i++) step(1, 0, 0, "R2 impulse tail");
    for (int i = 0; i < 3; i++) step(0, 7, 0, "R6 gap");
    // R9 full-scale positive and negative steps
    for (int i = 0; i < 16; i++) step(1, 32767, 0, "R9 pos step");
    for (int i = 0; i < 16; i++) step(1, -32768, 0, "R8 R9 neg step");
    // R8 alternating signs
    for (int i = 0; i < 20; i++) step(1, (i % 2) ? -1234 : 987, 0, "R8 alternating");
    // pseudo-random with gaps
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      step(seed[3:0] != 0, int'($signed(seed[30:15])), 0, "R3 R6 random");
    end
    // mid-stream reset
    step(1, 5000, 1, "R1 mid reset");
    step(1, 2, 0, "R1 after reset");
    step(1, 3, 0, "R3 after reset");
    for (int i = 0; i < 2; i++) step(0, 0, 0, "R6 final idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule